// File: doc/BRIEF.md
# Single-Operand Negate / Clear / Complement Unit

This execution unit carries out the four one-operand integer operations of a 16/32-bit CISC core: negate, negate with extend, clear and bitwise complement. Decode supplies a register operand, a two-bit operation code, a two-bit size code (byte, word or long), the current condition flags and a flag that says whether the operand came from memory. A one-cycle start strobe launches the operation.

One clock edge after the strobe, the unit presents these registered outputs:
- the result,
- the new X, N, Z, V and C flags,
- an illegal-size indication,
- the cycle count that the sequencer should charge.

Only the bytes inside the selected size change. All higher bytes pass through unchanged, so a partial register write keeps the rest of the register. Negate with extend chains over several precision words, so its Z flag can only be cleared and never set.

Top module: `unary_alu_exec`

## Requirements
- R1: A start pulse registers all outputs at the next rising clock edge. `done` is high for exactly that one cycle and low otherwise. `result`, `ccr_out`, `size_err` and `cycles` hold their values until the next start. The flags are packed as bit 4 = X, bit 3 = N, bit 2 = Z, bit 1 = V and bit 0 = C.
- R2: Operation code 2 (negate) produces 0 minus the sized operand.
  - C and X are set when the sized operand is nonzero.
  - V is set when both the operand and the result have their sign bit set (for example, negating 0x80 in a byte).
  - N is the result sign bit.
  - Z is set when the sized result is zero.
- R3: Operation code 0 (negate with extend) produces 0 minus the sized operand minus the incoming X.
  - C and X are set when the operand is nonzero or the incoming X is 1.
  - V and N follow the same rules as in R2.
- R4: In negate with extend, a nonzero sized result clears Z. A zero sized result leaves Z at its incoming value.
- R5: Operation code 1 (clear) produces a zero sized result whatever the operand is. It forces N=0, Z=1, V=0 and C=0 and leaves X unchanged.
- R6: Operation code 3 (complement) produces the bitwise inverse of the sized operand.
  - N and Z are taken from the sized result.
  - V and C are cleared.
  - X is unchanged.
- R7: Size codes are 0 = byte (bits 7:0), 1 = word (bits 15:0) and 2 = long (bits 31:0). Result bits above the selected size equal the operand's bits.
- R8: Size code 3 sets `size_err`. For this code, `result` equals the operand, `ccr_out` equals `ccr_in` and `cycles` is 0. Any valid size clears `size_err`.
- R9: `cycles` is 4 for byte and word operations and 6 for long operations. The count is doubled when `from_mem` is 1.
- R10: After reset, `done`, `result`, `ccr_out`, `size_err` and `cycles` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch the operation on the current inputs |
| op_type | input | 2 | 0 negate with extend, 1 clear, 2 negate, 3 complement |
| size_code | input | 2 | 0 byte, 1 word, 2 long, 3 illegal |
| operand | input | 32 | Register operand |
| ccr_in | input | 5 | Incoming flags {X,N,Z,V,C} |
| from_mem | input | 1 | Operand came from memory (timing only) |
| done | output | 1 | Results updated this cycle |
| result | output | 32 | Merged result |
| ccr_out | output | 5 | Updated flags {X,N,Z,V,C} |
| size_err | output | 1 | Illegal size code was given |
| cycles | output | 5 | Cycle count to charge |

## Verification
The properties assume that every input is stable and known in the cycle in which `start` is high. They also assume that `start` is never asserted during reset. The bench sets all inputs on the falling edge together with `start` and drops `start` one cycle later. It only asserts `start` once reset is released. The properties therefore read the inputs one cycle in the past, exactly at a start. They make no assumption about back-to-back starts, which the bench does not use.

// File: rtl/unary_pkg.sv
package unary_pkg;
   typedef enum logic [1:0] {
      OP_NEGX = 2'd0,
      OP_CLR  = 2'd1,
      OP_NEG  = 2'd2,
      OP_NOT  = 2'd3
   } unop_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_BAD  = 2'd3
   } usize_e;

   typedef struct packed {
      logic x;
      logic n;
      logic z;
      logic v;
      logic c;
   } ccr_t;
endpackage

// File: rtl/unary_size_ctl.sv
module unary_size_ctl #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [1:0]        size_code,
   output logic [DATA_W-1:0] lane_mask,
   output logic [SH_W-1:0]   shamt,
   output logic              bad
);
   import unary_pkg::*;
   localparam int LANES = DATA_W / LANE_W;
   localparam logic [SH_W-1:0] SH_BYTE = SH_W'(DATA_W - 8);
   localparam logic [SH_W-1:0] SH_WORD = SH_W'(DATA_W - 16);

   logic [$clog2(LANES+1)-1:0] active;

   always_comb begin
      bad    = 1'b0;
      active = '0;
      shamt  = '0;
      unique case (size_code)
         SZ_BYTE: begin active = ($clog2(LANES+1))'(8 / LANE_W);  shamt = SH_BYTE; end
         SZ_WORD: begin active = ($clog2(LANES+1))'(16 / LANE_W); shamt = SH_WORD; end
         SZ_LONG: begin active = ($clog2(LANES+1))'(LANES);       shamt = '0;      end
         default: bad = 1'b1;
      endcase
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_mask[i*LANE_W +: LANE_W] = (i < int'(active)) ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
   end
endmodule

// File: rtl/unary_core.sv
module unary_core #(
   parameter int DATA_W = 32,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [1:0]          op_type,
   input  logic [DATA_W-1:0]   operand,
   input  logic [DATA_W-1:0]   lane_mask,
   input  logic [SH_W-1:0]     shamt,
   input  unary_pkg::ccr_t     ccr_in,
   output logic [DATA_W-1:0]   sized_res,
   output unary_pkg::ccr_t     ccr_out
);
   import unary_pkg::*;

   logic [DATA_W-1:0] aligned, x_al, top_mask, top;
   logic [DATA_W:0]   neg_full, negx_full;

   always_comb begin
      aligned   = operand << shamt;
      top_mask  = lane_mask << shamt;
      x_al      = {{(DATA_W-1){1'b0}}, ccr_in.x} << shamt;
      neg_full  = {(DATA_W+1){1'b0}} - {1'b0, aligned};
      negx_full = neg_full - {1'b0, x_al};
      ccr_out   = ccr_in;
      top       = '0;
      unique case (op_type)
         OP_NEGX: begin
            top       = negx_full[DATA_W-1:0];
            ccr_out.c = negx_full[DATA_W];
            ccr_out.x = negx_full[DATA_W];
            ccr_out.n = top[DATA_W-1];
            ccr_out.v = aligned[DATA_W-1] & top[DATA_W-1];
            if (top != '0) ccr_out.z = 1'b0;
         end
         OP_CLR: begin
            top       = '0;
            ccr_out.n = 1'b0;
            ccr_out.z = 1'b1;
            ccr_out.v = 1'b0;
            ccr_out.c = 1'b0;
         end
         OP_NEG: begin
            top       = neg_full[DATA_W-1:0];
            ccr_out.c = neg_full[DATA_W];
            ccr_out.x = neg_full[DATA_W];
            ccr_out.n = top[DATA_W-1];
            ccr_out.v = aligned[DATA_W-1] & top[DATA_W-1];
            ccr_out.z = (top == '0);
         end
         default: begin
            top       = ~aligned & top_mask;
            ccr_out.n = top[DATA_W-1];
            ccr_out.z = (top == '0);
            ccr_out.v = 1'b0;
            ccr_out.c = 1'b0;
         end
      endcase
      sized_res = top >> shamt;
   end
endmodule

// File: rtl/unary_cycles.sv
module unary_cycles #(
   parameter int CYC_SHORT  = 4,
   parameter int CYC_LONG   = 6,
   parameter bit MEM_DOUBLE = 1'b1,
   parameter int MEM_EXTRA  = 4,
   parameter int CYC_W      = 5
) (
   input  logic [1:0]       size_code,
   input  logic             from_mem,
   output logic [CYC_W-1:0] cyc
);
   import unary_pkg::*;
   logic [CYC_W-1:0] base;

   assign base = (size_code == SZ_LONG) ? CYC_W'(CYC_LONG) : CYC_W'(CYC_SHORT);

   if (MEM_DOUBLE) begin : g_double
      assign cyc = from_mem ? (base << 1) : base;
   end else begin : g_add
      assign cyc = from_mem ? (base + CYC_W'(MEM_EXTRA)) : base;
   end
endmodule

// File: rtl/unary_alu_exec.sv
module unary_alu_exec #(
   parameter int DATA_W     = 32,
   parameter int LANE_W     = 8,
   parameter int CYC_SHORT  = 4,
   parameter int CYC_LONG   = 6,
   parameter bit MEM_DOUBLE = 1'b1,
   parameter int MEM_EXTRA  = 4,
   localparam int CYC_MAX   = 2 * ((CYC_LONG > CYC_SHORT) ? CYC_LONG : CYC_SHORT) + MEM_EXTRA,
   localparam int CYC_W     = $clog2(CYC_MAX + 1),
   localparam int FLG_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op_type,
   input  logic [1:0]        size_code,
   input  logic [DATA_W-1:0] operand,
   input  logic [FLG_W-1:0]  ccr_in,
   input  logic              from_mem,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic [FLG_W-1:0]  ccr_out,
   output logic              size_err,
   output logic [CYC_W-1:0]  cycles
);
   import unary_pkg::*;
   localparam int SH_W  = $clog2(DATA_W);
   localparam int LANES = DATA_W / LANE_W;

   if (DATA_W != 32) begin : g_chk_width
      $error("unary_alu_exec: DATA_W must be 32");
   end
   if (LANE_W != 8) begin : g_chk_lane
      $error("unary_alu_exec: LANE_W must be 8");
   end
   if (CYC_SHORT < 1 || CYC_LONG < CYC_SHORT) begin : g_chk_cyc
      $error("unary_alu_exec: cycle parameters out of range");
   end

   logic [DATA_W-1:0] lane_mask, sized_res, merged;
   logic [SH_W-1:0]   shamt;
   logic              bad;
   ccr_t              flg_in, flg_new;
   logic [CYC_W-1:0]  cyc_c;

   assign flg_in = ccr_t'(ccr_in);

   unary_size_ctl #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_size (
      .size_code (size_code),
      .lane_mask (lane_mask),
      .shamt     (shamt),
      .bad       (bad)
   );

   unary_core #(.DATA_W(DATA_W)) i_core (
      .op_type   (op_type),
      .operand   (operand),
      .lane_mask (lane_mask),
      .shamt     (shamt),
      .ccr_in    (flg_in),
      .sized_res (sized_res),
      .ccr_out   (flg_new)
   );

   unary_cycles #(
      .CYC_SHORT (CYC_SHORT), .CYC_LONG (CYC_LONG),
      .MEM_DOUBLE(MEM_DOUBLE), .MEM_EXTRA(MEM_EXTRA), .CYC_W(CYC_W)
   ) i_cyc (
      .size_code (size_code),
      .from_mem  (from_mem),
      .cyc       (cyc_c)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_merge
      assign merged[i*LANE_W +: LANE_W] = lane_mask[i*LANE_W]
                                        ? sized_res[i*LANE_W +: LANE_W]
                                        : operand[i*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         result   <= '0;
         ccr_out  <= '0;
         size_err <= 1'b0;
         cycles   <= '0;
      end else begin
         done <= start;
         if (start) begin
            size_err <= bad;
            if (bad) begin
               result  <= operand;
               ccr_out <= ccr_in;
               cycles  <= '0;
            end else begin
               result  <= merged;
               ccr_out <= flg_new;
               cycles  <= cyc_c;
            end
         end
      end
   end
endmodule

// File: rtl/unary_alu_exec_chk.sv
module unary_alu_exec_chk #(
   parameter int DATA_W = 32,
   parameter int CYC_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        op_type,
   input logic [1:0]        size_code,
   input logic [DATA_W-1:0] operand,
   input logic [4:0]        ccr_in,
   input logic              from_mem,
   input logic              done,
   input logic [DATA_W-1:0] result,
   input logic [4:0]        ccr_out,
   input logic              size_err,
   input logic [CYC_W-1:0]  cycles
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done); // R1
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done); // R1
   AST_NEG_XC: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !op_type[0] && size_code != 2'd3) |=> (ccr_out[4] == ccr_out[0])); // R2
   AST_NEGX_ZSTICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_type == 2'd0 && size_code != 2'd3 && !ccr_in[2]) |=> !ccr_out[2]); // R4
   AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_type == 2'd1 && size_code != 2'd3) |=> (ccr_out[3:0] == 4'b0100)); // R5
   AST_X_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op_type[0] && size_code != 2'd3) |=> (ccr_out[4] == $past(ccr_in[4]))); // R6
   AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (start && size_code == 2'd0) |=> (result[DATA_W-1:8] == $past(operand[DATA_W-1:8]))); // R7
   AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && size_code == 2'd3) |=> (size_err && cycles == '0)); // R8
   AST_MEM_CYC: assert property (@(posedge clk) disable iff (!rst_n)
      (start && size_code != 2'd3 && from_mem) |=> (cycles >= CYC_W'(8))); // R9
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !$past(start)) |=> $stable(result)); // R1
endmodule

bind unary_alu_exec unary_alu_exec_chk #(.DATA_W(DATA_W), .CYC_W(CYC_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op_type(op_type), .size_code(size_code),
   .operand(operand), .ccr_in(ccr_in), .from_mem(from_mem), .done(done),
   .result(result), .ccr_out(ccr_out), .size_err(size_err), .cycles(cycles)
);

// File: tb/test_unary_alu_exec.sv
module test_unary_alu_exec;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op_type = '0;
   logic [1:0]  size_code = '0;
   logic [31:0] operand = '0;
   logic [4:0]  ccr_in = '0;
   logic        from_mem = 1'b0;
   logic        done;
   logic [31:0] result;
   logic [4:0]  ccr_out;
   logic        size_err;
   logic [4:0]  cycles;

   int n_run  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   unary_alu_exec i_unary_alu_exec (
      .clk(clk), .rst_n(rst_n), .start(start), .op_type(op_type), .size_code(size_code),
      .operand(operand), .ccr_in(ccr_in), .from_mem(from_mem), .done(done),
      .result(result), .ccr_out(ccr_out), .size_err(size_err), .cycles(cycles)
   );

   task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic model(input logic [1:0] t, input logic [1:0] s, input logic [31:0] a,
                        input logic [4:0] f, input logic m,
                        output logic [31:0] r, output logic [4:0] fo, output logic [4:0] cy);
      int w;
      logic [31:0] mk, sa, sr, sb;
      logic c;
      fo = f;
      if (s == 2'd3) begin
         r = a; cy = 5'd0;
         return;
      end
      w  = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
      mk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
      sb = 32'd1 << (w - 1);
      sa = a & mk;
      sr = '0;
      case (t)
         2'd0: begin
            sr = (32'd0 - sa - {31'd0, f[4]}) & mk;
            c  = (sa != 0) || f[4];
            fo[4] = c; fo[0] = c;
            fo[3] = (sr & sb) != 0;
            fo[1] = ((sa & sb) != 0) && ((sr & sb) != 0);
            if (sr != 0) fo[2] = 1'b0;
         end
         2'd1: begin
            sr = '0; fo[3:0] = 4'b0100;
         end
         2'd2: begin
            sr = (32'd0 - sa) & mk;
            c  = sa != 0;
            fo[4] = c; fo[0] = c;
            fo[3] = (sr & sb) != 0;
            fo[1] = ((sa & sb) != 0) && ((sr & sb) != 0);
            fo[2] = sr == 0;
         end
         default: begin
            sr = ~sa & mk;
            fo[3] = (sr & sb) != 0;
            fo[2] = sr == 0;
            fo[1] = 1'b0; fo[0] = 1'b0;
         end
      endcase
      r  = (a & ~mk) | sr;
      cy = 5'((w == 32 ? 6 : 4) * (m ? 2 : 1));
   endtask

   task automatic run(input string req, input logic [1:0] t, input logic [1:0] s,
                      input logic [31:0] a, input logic [4:0] f, input logic m);
      logic [31:0] er;
      logic [4:0]  ef, ec;
      model(t, s, a, f, m, er, ef, ec);
      @(negedge clk);
      op_type = t; size_code = s; operand = a; ccr_in = f; from_mem = m; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check(req, "done",   {31'd0, done}, 32'd1);
      check(req, "result", result, er);
      check(req, "flags",  {27'd0, ccr_out}, {27'd0, ef});
      check(req, "cycles", {27'd0, cycles}, {27'd0, ec});
      check(req, "size_err", {31'd0, size_err}, {31'd0, (s == 2'd3)});
   endtask

   task automatic t_reset;
      check("R10", "done",   {31'd0, done}, 32'd0);
      check("R10", "result", result, 32'd0);
      check("R10", "flags",  {27'd0, ccr_out}, 32'd0);
      check("R10", "size_err", {31'd0, size_err}, 32'd0);
      check("R10", "cycles", {27'd0, cycles}, 32'd0);
   endtask

   task automatic t_neg;
      run("R2", 2'd2, 2'd0, 32'h1234_5680, 5'b00000, 1'b0);
      check("R2", "byte min V/C", {27'd0, ccr_out}, {27'd0, 5'b11011});
      run("R2", 2'd2, 2'd1, 32'h0000_0000, 5'b11111, 1'b0);
      check("R2", "zero Z", {27'd0, ccr_out}, {27'd0, 5'b00100});
      run("R2", 2'd2, 2'd2, 32'h0000_0001, 5'b00000, 1'b0);
      check("R2", "long -1", result, 32'hFFFF_FFFF);
   endtask

   task automatic t_negx;
      run("R3", 2'd0, 2'd0, 32'h0000_007F, 5'b10000, 1'b0);
      check("R3", "7F+X", result, 32'h0000_0080);
      run("R3", 2'd0, 2'd1, 32'h0000_8000, 5'b00100, 1'b0);
      run("R3", 2'd0, 2'd2, 32'h8000_0000, 5'b10100, 1'b0);
   endtask

   task automatic t_negx_sticky;
      run("R4", 2'd0, 2'd0, 32'h0000_0000, 5'b00000, 1'b0);
      check("R4", "Z stays 0", {31'd0, ccr_out[2]}, 32'd0);
      run("R4", 2'd0, 2'd0, 32'h0000_0000, 5'b00100, 1'b0);
      check("R4", "Z stays 1", {31'd0, ccr_out[2]}, 32'd1);
      run("R4", 2'd0, 2'd0, 32'h0000_00FF, 5'b10100, 1'b0);
      check("R4", "FF+X zero keeps Z", {27'd0, ccr_out}, {27'd0, 5'b10101});
      run("R4", 2'd0, 2'd1, 32'h0000_0003, 5'b00100, 1'b0);
      check("R4", "nonzero clears Z", {31'd0, ccr_out[2]}, 32'd0);
   endtask

   task automatic t_clear;
      run("R5", 2'd1, 2'd2, 32'hDEAD_BEEF, 5'b11011, 1'b0);
      check("R5", "long zero", result, 32'h0);
      run("R5", 2'd1, 2'd1, 32'hDEAD_BEEF, 5'b01011, 1'b1);
      check("R5", "word keep upper", result, 32'hDEAD_0000);
   endtask

   task automatic t_not;
      run("R6", 2'd3, 2'd0, 32'hAAAA_AA55, 5'b10011, 1'b0);
      check("R6", "byte inv", result, 32'hAAAA_AAAA);
      run("R6", 2'd3, 2'd2, 32'hFFFF_FFFF, 5'b00011, 1'b0);
      check("R6", "all ones to zero", {27'd0, ccr_out}, {27'd0, 5'b00100});
   endtask

   task automatic t_upper;
      run("R7", 2'd2, 2'd0, 32'hCAFE_F001, 5'b00000, 1'b0);
      check("R7", "byte upper", result, 32'hCAFE_F0FF);
      run("R7", 2'd2, 2'd1, 32'hCAFE_0001, 5'b00000, 1'b0);
      check("R7", "word upper", result, 32'hCAFE_FFFF);
   endtask

   task automatic t_badsize;
      run("R8", 2'd2, 2'd3, 32'h1357_9BDF, 5'b10101, 1'b1);
      check("R8", "err flag", {31'd0, size_err}, 32'd1);
      run("R8", 2'd3, 2'd0, 32'h0, 5'b0, 1'b0);
      check("R8", "err cleared", {31'd0, size_err}, 32'd0);
   endtask

   task automatic t_cycles;
      run("R9", 2'd2, 2'd0, 32'h5, 5'b0, 1'b0);
      check("R9", "byte reg", {27'd0, cycles}, 32'd4);
      run("R9", 2'd3, 2'd1, 32'h5, 5'b0, 1'b1);
      check("R9", "word mem", {27'd0, cycles}, 32'd8);
      run("R9", 2'd0, 2'd2, 32'h5, 5'b0, 1'b0);
      check("R9", "long reg", {27'd0, cycles}, 32'd6);
      run("R9", 2'd1, 2'd2, 32'h5, 5'b0, 1'b1);
      check("R9", "long mem", {27'd0, cycles}, 32'd12);
   endtask

   task automatic t_timing;
      logic [31:0] held;
      run("R1", 2'd2, 2'd2, 32'h0000_0010, 5'b0, 1'b0);
      held = result;
      operand = 32'h7777_7777;
      @(negedge clk);
      check("R1", "done drops", {31'd0, done}, 32'd0);
      @(negedge clk);
      check("R1", "result held", result, held);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_neg();
      t_negx();
      t_negx_sticky();
      t_clear();
      t_not();
      t_upper();
      t_badsize();
      t_cycles();
      t_timing();
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule